// File: doc/BRIEF.md
# Pad Pull Resistor Sequencer

This block drives a two-bit pull request to every pad of a bank of general-purpose pins. Software reaches it through a 32-bit register port, and it offers one of two programming schemes. A parameter picks the scheme when the block is built.

In the shared-control scheme there is one small control register that holds a single pull choice. Software writes that register first. It then raises bits in per-bank strobe words, and each pin whose strobe bit rises copies the shared choice into its own pull latch. The block counts a settle window after every control write. A strobe that arrives too early is held back until the window has run out. The pull state itself cannot be read back in this scheme; only the control value and the strobe words can be read.

In the packed scheme each pin owns a two-bit field, and sixteen pins share one word. Writing a word updates the pins at once, and the words read back as written.

Top module: `pull_seq_top`

## Requirements
- R1: After a synchronous reset, every pad output is code 0 (no pull), and the control word, the strobe words and the packed words all read 0.
- R2: The pad code is 0 for no pull, 1 for pull-up and 2 for pull-down. Code 3 never appears on any pad.
- R3: In the shared-control scheme, the control register at offset 0x94 keeps only bits [1:0] of a write. A read returns those two bits with the upper 30 bits at 0.
- R4: In the shared-control scheme, strobe word b sits at offset 0x98+4*b, and pin p uses bit p%32 of word p/32. A pin's latch updates only on a 0-to-1 change of its own strobe bit. Pins whose bits do not rise keep their state. Strobe words read back as written, with bits for absent pins at 0.
- R5: Shared control codes are 0 = off (pad 0), 1 = pull-down (pad 2) and 2 = pull-up (pad 1). Control code 3 leaves a strobed latch unchanged.
- R6: A pin latch never changes within SETTLE_CYCLES clock edges of the edge that accepted a control write. A strobe bit that rose early and is still high is applied on the first edge after the window ends. An early rise that is cleared before the window ends is dropped.
- R7: A strobe bit that stays high does not copy a later control value. The bit must fall and then rise again.
- R8: In the packed scheme, word w sits at offset 0xE4+4*w, and pin p uses bits [(p%16)*2+1:(p%16)*2] of word p/16. A write updates the pads on the next clock edge. A field written as 3 leaves that pin unchanged. Reads return the stored fields, with fields of absent pins at 0.
- R9: The scheme not selected by LEGACY_MODE is absent. Writes to its offsets change no pad, and reads of its offsets return 0.
- R10: Read data appears on the clock edge after a read strobe and holds until the next read. Unmapped offsets read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 12 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered |
| pad_pull | output | 2*NUM_PINS | Pull code per pin, pin p at bits [2p+1:2p] |

## Verification
Each result has a fixed number of clock edges after the cycle in which its stimulus is driven:
- Read data arrives one edge later.
- A packed-scheme pad also changes one edge later.
- A shared-scheme pad changes two edges after its strobe write, or SETTLE_CYCLES+2 edges after the control write, whichever is later.

The bench computes each due cycle from these counts when it drives the stimulus, and queues the expected value with that cycle attached. A monitor compares on exactly that cycle. Checks placed one cycle before a due cycle confirm that nothing changes early.

// File: rtl/pullseq_pkg.sv
package pullseq_pkg;

    localparam int REG_ADDR_W = 12;

    localparam logic [REG_ADDR_W-1:0] ADDR_LCTL = 12'h094;
    localparam logic [REG_ADDR_W-1:0] ADDR_LSTB = 12'h098;
    localparam logic [REG_ADDR_W-1:0] ADDR_DIR  = 12'h0E4;

    localparam int PINS_PER_BANK = 32;
    localparam int PINS_PER_WORD = 16;

    // Code presented to the pads (also the packed-scheme field code)
    typedef enum logic [1:0] {
        PAD_NONE = 2'd0,
        PAD_UP   = 2'd1,
        PAD_DOWN = 2'd2,
        PAD_RSVD = 2'd3
    } pad_pull_e;

    // Code held in the shared control register
    typedef enum logic [1:0] {
        LG_OFF  = 2'd0,
        LG_DOWN = 2'd1,
        LG_UP   = 2'd2,
        LG_RSVD = 2'd3
    } legacy_ctl_e;

    function automatic logic [REG_ADDR_W-1:0] word_addr(
        input logic [REG_ADDR_W-1:0] base, input int idx);
        return base + REG_ADDR_W'(idx * 4);
    endfunction

    function automatic pad_pull_e legacy_to_pad(input legacy_ctl_e c);
        case (c)
            LG_DOWN: return PAD_DOWN;
            LG_UP:   return PAD_UP;
            default: return PAD_NONE;
        endcase
    endfunction

    // Bits of strobe bank b that belong to real pins
    function automatic logic [31:0] bank_valid_mask(input int num_pins, input int bank);
        logic [31:0] m;
        for (int i = 0; i < PINS_PER_BANK; i++)
            m[i] = (bank * PINS_PER_BANK + i) < num_pins;
        return m;
    endfunction

endpackage

// File: rtl/pull_regif.sv
module pull_regif
    import pullseq_pkg::*;
#(
    parameter int LBANKS      = 2,
    parameter int DWORDS      = 4,
    parameter bit LEGACY_MODE = 1'b1
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           bus_wr,
    input  logic                           bus_rd,
    input  logic [REG_ADDR_W-1:0]          bus_addr,
    input  logic [1:0]                     ctl_val,
    input  logic [LBANKS-1:0][31:0]        stb_val,
    input  logic [DWORDS-1:0][31:0]        dir_val,
    output logic                           ctl_we,
    output logic [LBANKS-1:0]              stb_we,
    output logic [DWORDS-1:0]              dir_we,
    output logic [31:0]                    bus_rdata
);

    logic [31:0] rd_next;

    // Write decode: the absent scheme never gets a write enable
    always_comb begin
        ctl_we = LEGACY_MODE && bus_wr && (bus_addr == ADDR_LCTL);
        for (int b = 0; b < LBANKS; b++)
            stb_we[b] = LEGACY_MODE && bus_wr && (bus_addr == word_addr(ADDR_LSTB, b));
        for (int w = 0; w < DWORDS; w++)
            dir_we[w] = !LEGACY_MODE && bus_wr && (bus_addr == word_addr(ADDR_DIR, w));
    end

    // Read mux; unmapped offsets fall through to zero
    always_comb begin
        rd_next = '0;
        if (bus_addr == ADDR_LCTL)
            rd_next = {30'b0, ctl_val};
        for (int b = 0; b < LBANKS; b++)
            if (bus_addr == word_addr(ADDR_LSTB, b))
                rd_next = stb_val[b];
        for (int w = 0; w < DWORDS; w++)
            if (bus_addr == word_addr(ADDR_DIR, w))
                rd_next = dir_val[w];
    end

    always_ff @(posedge clk) begin
        if (rst)
            bus_rdata <= '0;
        else if (bus_rd)
            bus_rdata <= rd_next;
    end

endmodule

// File: rtl/pull_legacy_seq.sv
module pull_legacy_seq
    import pullseq_pkg::*;
#(
    parameter int NUM_PINS      = 58,
    parameter int LBANKS        = 2,
    parameter int SETTLE_CYCLES = 150
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        ctl_we,
    input  logic [LBANKS-1:0]           stb_we,
    input  logic [31:0]                 wdata,
    output logic [1:0]                  ctl_val,
    output logic [LBANKS-1:0][31:0]     stb_val,
    output pad_pull_e [NUM_PINS-1:0]    pads
);

    localparam int CW = $clog2(SETTLE_CYCLES + 1);
    localparam logic [CW-1:0] CNT_MAX = CW'(SETTLE_CYCLES);

    legacy_ctl_e             ctl_q;
    logic [LBANKS-1:0][31:0] stb_q;
    logic [CW-1:0]           settle_cnt;
    logic                    armed;

    // Control register and settle counter. After reset the window is
    // treated as already expired.
    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q      <= LG_OFF;
            settle_cnt <= CNT_MAX;
        end else if (ctl_we) begin
            ctl_q      <= legacy_ctl_e'(wdata[1:0]);
            settle_cnt <= '0;
        end else if (settle_cnt != CNT_MAX) begin
            settle_cnt <= settle_cnt + 1'b1;
        end
    end

    assign armed = (settle_cnt == CNT_MAX);

    // Strobe words, masked to the pins that exist
    always_ff @(posedge clk) begin
        if (rst) begin
            stb_q <= '0;
        end else begin
            for (int b = 0; b < LBANKS; b++)
                if (stb_we[b])
                    stb_q[b] <= wdata & bank_valid_mask(NUM_PINS, b);
        end
    end

    assign ctl_val = ctl_q;
    assign stb_val = stb_q;

    // Per-pin latch. "seen" is the strobe level already consumed. While the
    // window is open it can only drop, so a rise stays pending until expiry.
    for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
        localparam int B = p / PINS_PER_BANK;
        localparam int I = p % PINS_PER_BANK;

        pad_pull_e latch_q;
        logic      seen_q;
        logic      stb_bit;

        assign stb_bit = stb_q[B][I];

        always_ff @(posedge clk) begin
            if (rst) begin
                latch_q <= PAD_NONE;
                seen_q  <= 1'b0;
            end else begin
                if (armed && stb_bit && !seen_q && (ctl_q != LG_RSVD))
                    latch_q <= legacy_to_pad(ctl_q);
                seen_q <= armed ? stb_bit : (seen_q & stb_bit);
            end
        end

        assign pads[p] = latch_q;
    end

endmodule

// File: rtl/pull_direct_regs.sv
module pull_direct_regs
    import pullseq_pkg::*;
#(
    parameter int NUM_PINS = 58,
    parameter int DWORDS   = 4
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic [DWORDS-1:0]           dir_we,
    input  logic [31:0]                 wdata,
    output logic [DWORDS-1:0][31:0]     dir_val,
    output pad_pull_e [NUM_PINS-1:0]    pads
);

    for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
        localparam int W = p / PINS_PER_WORD;
        localparam int S = (p % PINS_PER_WORD) * 2;

        pad_pull_e fld_q;
        logic [1:0] new_code;

        assign new_code = wdata[S +: 2];

        always_ff @(posedge clk) begin
            if (rst)
                fld_q <= PAD_NONE;
            else if (dir_we[W] && (new_code != PAD_RSVD))
                fld_q <= pad_pull_e'(new_code);
        end

        assign pads[p] = fld_q;
    end

    always_comb begin
        dir_val = '0;
        for (int p = 0; p < NUM_PINS; p++)
            dir_val[p / PINS_PER_WORD][(p % PINS_PER_WORD) * 2 +: 2] = pads[p];
    end

endmodule

// File: rtl/pull_seq_top.sv
module pull_seq_top
    import pullseq_pkg::*;
#(
    parameter int NUM_PINS      = 58,
    parameter bit LEGACY_MODE   = 1'b1,
    parameter int SETTLE_CYCLES = 150
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    bus_wr,
    input  logic                    bus_rd,
    input  logic [11:0]             bus_addr,
    input  logic [31:0]             bus_wdata,
    output logic [31:0]             bus_rdata,
    output logic [2*NUM_PINS-1:0]   pad_pull
);

    localparam int LBANKS = (NUM_PINS + PINS_PER_BANK - 1) / PINS_PER_BANK;
    localparam int DWORDS = (NUM_PINS + PINS_PER_WORD - 1) / PINS_PER_WORD;

    logic                    ctl_we;
    logic [LBANKS-1:0]       stb_we;
    logic [DWORDS-1:0]       dir_we;
    logic [1:0]              ctl_val;
    logic [LBANKS-1:0][31:0] stb_val;
    logic [DWORDS-1:0][31:0] dir_val;
    pad_pull_e [NUM_PINS-1:0] pads;

    pull_regif #(
        .LBANKS      (LBANKS),
        .DWORDS      (DWORDS),
        .LEGACY_MODE (LEGACY_MODE)
    ) u_regif (
        .clk       (clk),
        .rst       (rst),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_addr  (bus_addr),
        .ctl_val   (ctl_val),
        .stb_val   (stb_val),
        .dir_val   (dir_val),
        .ctl_we    (ctl_we),
        .stb_we    (stb_we),
        .dir_we    (dir_we),
        .bus_rdata (bus_rdata)
    );

    if (LEGACY_MODE) begin : g_legacy
        logic unused_dir;
        assign unused_dir = ^dir_we;
        assign dir_val    = '0;

        pull_legacy_seq #(
            .NUM_PINS      (NUM_PINS),
            .LBANKS        (LBANKS),
            .SETTLE_CYCLES (SETTLE_CYCLES)
        ) u_seq (
            .clk     (clk),
            .rst     (rst),
            .ctl_we  (ctl_we),
            .stb_we  (stb_we),
            .wdata   (bus_wdata),
            .ctl_val (ctl_val),
            .stb_val (stb_val),
            .pads    (pads)
        );
    end else begin : g_direct
        logic unused_legacy;
        assign unused_legacy = ^{ctl_we, stb_we};
        assign ctl_val       = '0;
        assign stb_val       = '0;

        pull_direct_regs #(
            .NUM_PINS (NUM_PINS),
            .DWORDS   (DWORDS)
        ) u_dir (
            .clk     (clk),
            .rst     (rst),
            .dir_we  (dir_we),
            .wdata   (bus_wdata),
            .dir_val (dir_val),
            .pads    (pads)
        );
    end

    assign pad_pull = pads;

endmodule

// File: rtl/pull_seq_chk.sv
module pull_seq_chk
    import pullseq_pkg::*;
#(
    parameter int NUM_PINS      = 58,
    parameter bit LEGACY_MODE   = 1'b1,
    parameter int SETTLE_CYCLES = 150
) (
    input logic                  clk,
    input logic                  rst,
    input logic                  bus_wr,
    input logic                  bus_rd,
    input logic [11:0]           bus_addr,
    input logic [31:0]           bus_rdata,
    input logic [2*NUM_PINS-1:0] pad_pull
);

    localparam int DWORDS = (NUM_PINS + PINS_PER_WORD - 1) / PINS_PER_WORD;
    localparam int SW = $clog2(SETTLE_CYCLES + 1);
    localparam logic [SW-1:0] SMAX = SW'(SETTLE_CYCLES);

    logic          has_rsvd;
    logic          dir_hit;
    logic [SW-1:0] since_ctl;

    always_comb begin
        has_rsvd = 1'b0;
        for (int p = 0; p < NUM_PINS; p++)
            if (pad_pull[2*p +: 2] == 2'b11)
                has_rsvd = 1'b1;
    end

    assign dir_hit = bus_wr && (bus_addr >= ADDR_DIR)
                     && (bus_addr < word_addr(ADDR_DIR, DWORDS));

    // Edges since the last control write, measured from the bus
    always_ff @(posedge clk) begin
        if (rst)
            since_ctl <= SMAX;
        else if (bus_wr && bus_addr == ADDR_LCTL)
            since_ctl <= '0;
        else if (since_ctl != SMAX)
            since_ctl <= since_ctl + 1'b1;
    end

    // R1
    reset_pads_chk: assert property (@(posedge clk)
        rst |=> (pad_pull == '0));

    // R2
    no_rsvd_code_chk: assert property (@(posedge clk) disable iff (rst)
        !has_rsvd);

    // R10
    rdata_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !bus_rd |=> $stable(bus_rdata));

    if (LEGACY_MODE) begin : g_leg
        // R6
        settle_gap_chk: assert property (@(posedge clk) disable iff (rst)
            (!$past(rst) && (pad_pull != $past(pad_pull))) |-> ($past(since_ctl) >= SMAX));
    end else begin : g_dir
        // R8
        direct_cause_chk: assert property (@(posedge clk) disable iff (rst)
            (!$past(rst) && (pad_pull != $past(pad_pull))) |-> $past(dir_hit));
    end

endmodule

bind pull_seq_top pull_seq_chk #(
    .NUM_PINS      (NUM_PINS),
    .LEGACY_MODE   (LEGACY_MODE),
    .SETTLE_CYCLES (SETTLE_CYCLES)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_addr  (bus_addr),
    .bus_rdata (bus_rdata),
    .pad_pull  (pad_pull)
);

// File: tb/pull_seq_top_tb.sv
module pull_seq_top_tb;

    localparam int NP = 58;
    localparam int ST = 150;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          bus_wr = 1'b0;
    logic          bus_rd = 1'b0;
    logic [11:0]   bus_addr = '0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   rdata_l, rdata_d;
    logic [2*NP-1:0] pad_l, pad_d;

    int cyc = 0;
    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    pull_seq_top #(.NUM_PINS(NP), .LEGACY_MODE(1'b1), .SETTLE_CYCLES(ST)) u_dut (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(rdata_l), .pad_pull(pad_l));

    pull_seq_top #(.NUM_PINS(NP), .LEGACY_MODE(1'b0), .SETTLE_CYCLES(ST)) u_dir (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(rdata_d), .pad_pull(pad_d));

    // kind: 0 shared pad, 1 shared rdata, 2 packed pad, 3 packed rdata
    typedef struct {
        int          due;
        string       req;
        int          kind;
        int          pin;
        logic [31:0] exp;
    } exp_t;

    exp_t sb[$];

    task automatic expect_at(input int due, input string req, input int kind,
                             input int pin, input logic [31:0] exp);
        sb.push_back('{due, req, kind, pin, exp});
    endtask

    function automatic logic [31:0] observe(input int kind, input int pin);
        case (kind)
            0:       return {30'b0, pad_l[2*pin +: 2]};
            1:       return rdata_l;
            2:       return {30'b0, pad_d[2*pin +: 2]};
            default: return rdata_d;
        endcase
    endfunction

    // Monitor: compare every queued item on its due cycle
    always @(negedge clk) begin
        if (!rst) begin
            for (int i = sb.size() - 1; i >= 0; i--) begin
                if (sb[i].due == cyc) begin
                    logic [31:0] act;
                    act = observe(sb[i].kind, sb[i].pin);
                    checks++;
                    if (act !== sb[i].exp) begin
                        errors++;
                        $display("FAIL %s kind=%0d pin=%0d actual=%h expected=%h",
                                 sb[i].req, sb[i].kind, sb[i].pin, act, sb[i].exp);
                    end
                    sb.delete(i);
                end
            end
        end
    end

    // Driver tasks: called at a falling edge, drive for one cycle
    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd_chk(input logic [11:0] a, input logic [31:0] exp_l,
                          input logic [31:0] exp_d, input string req);
        expect_at(cyc + 1, req, 1, 0, exp_l);
        expect_at(cyc + 1, req, 3, 0, exp_d);
        bus_rd = 1'b1; bus_addr = a;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        int tn;
        repeat (4) @(negedge clk);
        rst = 1'b0;

        // R1: reset state
        expect_at(cyc + 1, "R1", 0, 0, 0);
        expect_at(cyc + 1, "R1", 0, 57, 0);
        expect_at(cyc + 1, "R1", 2, 0, 0);
        expect_at(cyc + 1, "R1", 2, 57, 0);
        rd_chk(12'h094, 32'h0, 32'h0, "R1");
        rd_chk(12'h098, 32'h0, 32'h0, "R1");
        rd_chk(12'h0E4, 32'h0, 32'h0, "R1");

        // R6/R4/R5: pull-up, strobes written inside the settle window
        tn = cyc;
        expect_at(tn + ST + 1, "R6", 0, 3, 0);
        expect_at(tn + ST + 2, "R5", 0, 3, 1);
        expect_at(tn + ST + 2, "R4", 0, 31, 1);
        expect_at(tn + ST + 2, "R4", 0, 32, 1);
        expect_at(tn + ST + 2, "R4", 0, 57, 1);
        expect_at(tn + ST + 2, "R4", 0, 5, 0);
        expect_at(tn + ST + 2, "R9", 2, 3, 0);
        wr(12'h094, 32'h2);
        wr(12'h098, 32'h8000_0008);
        wr(12'h09C, 32'hFFFF_FFFF);
        idle(ST + 5);
        rd_chk(12'h098, 32'h8000_0008, 32'h0, "R4");
        rd_chk(12'h09C, 32'h03FF_FFFF, 32'h0, "R4");

        // R3: only the low two control bits are kept (01 = pull-down)
        wr(12'h094, 32'hFFFF_FFF5);
        rd_chk(12'h094, 32'h1, 32'h0, "R3");
        idle(ST + 10);
        // R7: strobe still high, no recapture; fall then rise applies it
        tn = cyc;
        expect_at(tn + 2, "R7", 0, 3, 1);
        expect_at(tn + 3, "R5", 0, 3, 2);
        expect_at(tn + 3, "R4", 0, 31, 1);
        wr(12'h098, 32'h0);
        wr(12'h098, 32'h0000_0008);

        // R5: reserved control code leaves the latch alone
        wr(12'h094, 32'h3);
        idle(ST + 5);
        tn = cyc;
        expect_at(tn + 3, "R5", 0, 3, 2);
        wr(12'h098, 32'h0);
        wr(12'h098, 32'h0000_0008);
        idle(3);

        // R5: off code clears a pin; R4: untouched pin keeps its state
        wr(12'h094, 32'h0);
        idle(ST + 5);
        tn = cyc;
        expect_at(tn + 3, "R5", 0, 31, 0);
        expect_at(tn + 3, "R4", 0, 3, 2);
        wr(12'h098, 32'h0);
        wr(12'h098, 32'h8000_0000);
        idle(3);

        // R6: early rise that is cleared inside the window is dropped
        tn = cyc;
        expect_at(tn + ST + 10, "R6", 0, 7, 0);
        expect_at(tn + ST + 10, "R6", 0, 3, 2);
        wr(12'h094, 32'h2);
        wr(12'h098, 32'h0000_0080);
        wr(12'h098, 32'h0);
        idle(ST + 15);

        // R8/R2: packed scheme, a code-3 field is ignored
        tn = cyc;
        expect_at(tn + 1, "R2", 2, 0, 1);
        expect_at(tn + 1, "R8", 2, 1, 2);
        expect_at(tn + 1, "R8", 2, 2, 0);
        expect_at(tn + 1, "R8", 2, 15, 2);
        expect_at(tn + 2, "R9", 0, 0, 0);
        wr(12'h0E4, 32'h8000_0039);
        rd_chk(12'h0E4, 32'h0, 32'h8000_0009, "R8");
        tn = cyc;
        expect_at(tn + 1, "R8", 2, 2, 1);
        expect_at(tn + 1, "R8", 2, 1, 2);
        wr(12'h0E4, 32'hFFFF_FFDF);
        rd_chk(12'h0E4, 32'h0, 32'h8000_0019, "R8");

        // R8: last word, fields of absent pins read 0
        tn = cyc;
        expect_at(tn + 1, "R8", 2, 57, 2);
        wr(12'h0F0, 32'hAAA8_0000);
        rd_chk(12'h0F0, 32'h0, 32'h0008_0000, "R8");

        // R9: shared offsets read 0 in packed mode; R10: unmapped, hold
        rd_chk(12'h094, 32'h2, 32'h0, "R9");
        rd_chk(12'h200, 32'h0, 32'h0, "R10");
        rd_chk(12'h0E4, 32'h0, 32'h8000_0019, "R10");
        tn = cyc;
        expect_at(tn + 2, "R10", 3, 0, 32'h8000_0019);
        idle(5);

        if (sb.size() != 0) begin
            errors += sb.size();
            checks += sb.size();
            $display("FAIL unchecked items=%0d actual=%0d expected=0", sb.size(), sb.size());
        end
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        wait (cyc > 50000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=%0d expected<50000", cyc);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule